// File: doc/BRIEF.md
# Effective Address and Cycle Penalty Unit

This unit sits beside the decoder of an 8-bit processor with a 16-bit address space. For each instruction it takes the operand bytes, the index registers and the pointer bytes already fetched from page zero, and computes the effective address. It also works out whether indexing moved the address into a different 256-byte page. From the instruction class and that result it adds the extra cycles the instruction costs. A base cycle count taken from the opcode table comes in with each instruction, and the unit adds the penalty to it.

For indirect modes the unit gives out the two page-zero pointer addresses combinationally, so the surrounding logic can fetch the pointer bytes in the same cycle. The effective address, the page-cross flag and the total cycle count are registered. They appear one clock after the instruction is presented. Branches take their own path: the target is the address of the next instruction plus a signed 8-bit offset, and the taken penalty has two levels. Opcode decoding and arithmetic are handled elsewhere.

Top module: `addr_penalty_unit`

## Requirements
- R1: Mode codes are 4 = absolute,X and 5 = absolute,Y. The 16-bit address {op_hi, op_lo} plus the zero-extended index wraps modulo 65536. page_cross is 1 when the upper byte of the result differs from op_hi.
- R2: Mode codes are 0 = zero page, 1 = zero page,X, 2 = zero page,Y and 3 = absolute. Indexed zero-page sums wrap within 8 bits and the upper address byte is 0. Absolute ignores both index registers. None of these modes, nor mode 6, ever sets page_cross.
- R3: Mode 6 (indexed indirect): ptr_lo_addr = op_lo + X mod 256 and ptr_hi_addr = ptr_lo_addr + 1 mod 256. The effective address is {ptr_hi_data, ptr_lo_data}.
- R4: Mode 7 (indirect indexed): ptr_lo_addr = op_lo and ptr_hi_addr = op_lo + 1 mod 256. The effective address is {ptr_hi_data, ptr_lo_data} + Y mod 65536. page_cross follows the rule of R1 against the pointer value.
- R5: Class code 0 (read) adds 1 cycle when page_cross is set and 0 otherwise.
- R6: Class codes 1 (store) and 2 (read-modify-write) add no cycles, even when page_cross is set.
- R7: Class code 3 (branch) ignores the mode. The effective address is pc_next plus the sign-extended op_lo, mod 65536. page_cross is 1 when the upper byte of the target differs from that of pc_next.
- R8: A taken branch adds 1 cycle, plus 1 more when page_cross is set. A branch that is not taken adds 0.
- R9: eff_addr, page_cross, total_cycles and out_valid update at the first rising edge at which in_valid is 1. out_valid stays high exactly while in_valid was high at the previous edge. While in_valid is 0, eff_addr, page_cross and total_cycles hold their values.
- R10: During reset all registered outputs are 0. total_cycles is one bit wider than base_cycles, so base 15 plus the largest penalty of 2 gives 17 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction fields valid this cycle |
| mode_sel | input | 3 | Addressing mode code |
| class_sel | input | 2 | Instruction class code |
| op_lo | input | 8 | First operand byte (also the branch offset) |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| ptr_lo_data | input | 8 | Byte read at ptr_lo_addr |
| ptr_hi_data | input | 8 | Byte read at ptr_hi_addr |
| pc_next | input | 16 | Address following the branch offset byte |
| br_taken | input | 1 | Branch condition true |
| base_cycles | input | 4 | Base cycle count from the opcode table |
| ptr_lo_addr | output | 8 | Page-zero address of the pointer low byte |
| ptr_hi_addr | output | 8 | Page-zero address of the pointer high byte |
| eff_addr | output | 16 | Registered effective address |
| page_cross | output | 1 | Registered page-cross flag |
| total_cycles | output | 5 | Registered base count plus penalties |
| out_valid | output | 1 | Registered outputs belong to an instruction |

## Verification
The bench goes after the carries that wrap. An absolute,X sum that rolls past 0xFFFF must still flag a cross. A zero-page,X sum that carries must land back in page zero; a design that lets the carry through would give an address in page 1. A pointer at 0xFF must take its high byte from 0x00, not 0x100. Store and read-modify-write instructions that do cross a page must keep their base count; a design that charges every class alike would add a cycle there. For branches, backward offsets and a not-taken branch with a cross are checked; a design that treated the offset as unsigned, or charged the cross without the taken cycle, would report the wrong target or count. A base of 15 plus two penalty cycles shows whether the sum is truncated.

// File: rtl/ap_pkg.sv
package ap_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  typedef enum logic [2:0] {
    M_ZP   = 3'd0,
    M_ZPX  = 3'd1,
    M_ZPY  = 3'd2,
    M_ABS  = 3'd3,
    M_ABSX = 3'd4,
    M_ABSY = 3'd5,
    M_INDX = 3'd6,
    M_INDY = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    C_READ   = 2'd0,
    C_STORE  = 2'd1,
    C_RMW    = 2'd2,
    C_BRANCH = 2'd3
  } iclass_e;

  // upper byte comparison: the page-cross rule
  function automatic logic pages_differ(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:DW] != b[AW-1:DW];
  endfunction

  function automatic logic [AW-1:0] join_bytes(input logic [DW-1:0] hi, input logic [DW-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [AW-1:0] sign_ext(input logic [DW-1:0] v);
    return {{DW{v[DW-1]}}, v};
  endfunction

  function automatic logic [AW-1:0] zero_ext(input logic [DW-1:0] v);
    return {{DW{1'b0}}, v};
  endfunction
endpackage

// File: rtl/ap_addr_gen.sv
module ap_addr_gen
  import ap_pkg::*;
(
  input  amode_e          mode,
  input  logic [DW-1:0]   op_lo,
  input  logic [DW-1:0]   op_hi,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  input  logic [DW-1:0]   ptr_lo_data,
  input  logic [DW-1:0]   ptr_hi_data,
  output logic [DW-1:0]   ptr_lo_addr,
  output logic [DW-1:0]   ptr_hi_addr,
  output logic [AW-1:0]   eff_addr,
  output logic            idx_cross
);
  logic [AW-1:0] abs_base;
  logic [AW-1:0] ptr_value;
  logic [DW-1:0] zp_sum_x;
  logic [DW-1:0] zp_sum_y;
  logic [DW-1:0] ptr_base;

  always_comb begin
    abs_base   = join_bytes(op_hi, op_lo);
    zp_sum_x   = op_lo + idx_x;
    zp_sum_y   = op_lo + idx_y;
    ptr_base   = (mode == M_INDX) ? zp_sum_x : op_lo;
    ptr_lo_addr = ptr_base;
    ptr_hi_addr = ptr_base + DW'(1);
    ptr_value  = join_bytes(ptr_hi_data, ptr_lo_data);

    eff_addr  = abs_base;
    idx_cross = 1'b0;
    case (mode)
      M_ZP:   eff_addr = zero_ext(op_lo);
      M_ZPX:  eff_addr = zero_ext(zp_sum_x);
      M_ZPY:  eff_addr = zero_ext(zp_sum_y);
      M_ABS:  eff_addr = abs_base;
      M_ABSX: begin
        eff_addr  = abs_base + zero_ext(idx_x);
        idx_cross = pages_differ(abs_base, eff_addr);
      end
      M_ABSY: begin
        eff_addr  = abs_base + zero_ext(idx_y);
        idx_cross = pages_differ(abs_base, eff_addr);
      end
      M_INDX: eff_addr = ptr_value;
      M_INDY: begin
        eff_addr  = ptr_value + zero_ext(idx_y);
        idx_cross = pages_differ(ptr_value, eff_addr);
      end
      default: eff_addr = abs_base;
    endcase
  end
endmodule

// File: rtl/ap_branch_tgt.sv
module ap_branch_tgt
  import ap_pkg::*;
(
  input  logic [AW-1:0] pc_next,
  input  logic [DW-1:0] offset,
  output logic [AW-1:0] target,
  output logic          br_cross
);
  always_comb begin
    target   = pc_next + sign_ext(offset);
    br_cross = pages_differ(pc_next, target);
  end
endmodule

// File: rtl/ap_penalty.sv
module ap_penalty
  import ap_pkg::*;
(
  input  iclass_e    cls,
  input  logic       idx_cross,
  input  logic       br_cross,
  input  logic       taken,
  output logic       cross_sel,
  output logic [1:0] extra
);
  always_comb begin
    cross_sel = 1'b0;
    extra     = 2'd0;
    case (cls)
      C_READ: begin
        cross_sel = idx_cross;
        extra     = {1'b0, idx_cross};
      end
      C_STORE, C_RMW: begin
        cross_sel = idx_cross;
        extra     = 2'd0;
      end
      C_BRANCH: begin
        cross_sel = br_cross;
        extra     = taken ? (2'd1 + {1'b0, br_cross}) : 2'd0;
      end
      default: extra = 2'd0;
    endcase
  end
endmodule

// File: rtl/addr_penalty_unit.sv
module addr_penalty_unit
  import ap_pkg::*;
#(
  parameter int BASE_W = 4,
  localparam int TOT_W = BASE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        mode_sel,
  input  logic [1:0]        class_sel,
  input  logic [7:0]        op_lo,
  input  logic [7:0]        op_hi,
  input  logic [7:0]        idx_x,
  input  logic [7:0]        idx_y,
  input  logic [7:0]        ptr_lo_data,
  input  logic [7:0]        ptr_hi_data,
  input  logic [15:0]       pc_next,
  input  logic              br_taken,
  input  logic [BASE_W-1:0] base_cycles,
  output logic [7:0]        ptr_lo_addr,
  output logic [7:0]        ptr_hi_addr,
  output logic [15:0]       eff_addr,
  output logic              page_cross,
  output logic [TOT_W-1:0]  total_cycles,
  output logic              out_valid
);
  amode_e        mode;
  iclass_e       cls;
  logic [AW-1:0] idx_addr;
  logic          idx_cross;
  logic [AW-1:0] br_target;
  logic          br_cross;
  logic          cross_sel;
  logic [1:0]    extra;
  logic [AW-1:0] next_addr;
  logic [TOT_W-1:0] next_total;

  assign mode = amode_e'(mode_sel);
  assign cls  = iclass_e'(class_sel);

  ap_addr_gen u_addr (
    .mode        (mode),
    .op_lo       (op_lo),
    .op_hi       (op_hi),
    .idx_x       (idx_x),
    .idx_y       (idx_y),
    .ptr_lo_data (ptr_lo_data),
    .ptr_hi_data (ptr_hi_data),
    .ptr_lo_addr (ptr_lo_addr),
    .ptr_hi_addr (ptr_hi_addr),
    .eff_addr    (idx_addr),
    .idx_cross   (idx_cross)
  );

  ap_branch_tgt u_branch (
    .pc_next  (pc_next),
    .offset   (op_lo),
    .target   (br_target),
    .br_cross (br_cross)
  );

  ap_penalty u_pen (
    .cls       (cls),
    .idx_cross (idx_cross),
    .br_cross  (br_cross),
    .taken     (br_taken),
    .cross_sel (cross_sel),
    .extra     (extra)
  );

  assign next_addr  = (cls == C_BRANCH) ? br_target : idx_addr;
  assign next_total = TOT_W'(base_cycles) + TOT_W'(extra);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_addr     <= '0;
      page_cross   <= 1'b0;
      total_cycles <= '0;
      out_valid    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        eff_addr     <= next_addr;
        page_cross   <= cross_sel;
        total_cycles <= next_total;
      end
    end
  end

  // R2: modes without a 16-bit index sum never report a cross
  a_r2_no_cross_flat: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cls != C_BRANCH &&
    (mode == M_ZP || mode == M_ZPX || mode == M_ZPY || mode == M_ABS || mode == M_INDX)
    |=> !page_cross);

  // R5: read class charges exactly the indexing cross
  a_r5_read_penalty: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cls == C_READ
    |=> total_cycles == TOT_W'($past(base_cycles)) + TOT_W'($past(idx_cross)));

  // R6: store and read-modify-write keep the base count
  a_r6_no_write_penalty: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (cls == C_STORE || cls == C_RMW)
    |=> total_cycles == TOT_W'($past(base_cycles)));

  // R8: taken branch charges one plus the target-page cross
  a_r8_taken_branch: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cls == C_BRANCH && br_taken
    |=> total_cycles == TOT_W'($past(base_cycles)) + TOT_W'(1) + TOT_W'($past(br_cross)));

  // R8: untaken branch charges nothing
  a_r8_untaken_branch: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cls == C_BRANCH && !br_taken
    |=> total_cycles == TOT_W'($past(base_cycles)));

  // R9: valid follows the input one cycle later
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9: idle cycles hold the registered results
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(eff_addr) && $stable(total_cycles) && $stable(page_cross));
endmodule

// File: tb/addr_penalty_unit_test.sv
module addr_penalty_unit_test;
  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  cls;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [7:0]  x;
    logic [7:0]  y;
    logic [7:0]  plo;
    logic [7:0]  phi;
    logic [15:0] pcn;
    logic        tk;
    logic [3:0]  base;
    logic [15:0] e_addr;
    logic        e_cross;
    logic [4:0]  e_cyc;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{3'd4, 2'd0, 8'hF0, 8'h12, 8'h20, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 4'd4, 16'h1310, 1'b1, 5'd5}, // R1 R5
    '{3'd4, 2'd0, 8'h10, 8'h12, 8'h20, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 4'd4, 16'h1230, 1'b0, 5'd4}, // R1
    '{3'd5, 2'd1, 8'hFF, 8'h20, 8'h00, 8'h01, 8'h00, 8'h00, 16'h0000, 1'b0, 4'd5, 16'h2100, 1'b1, 5'd5}, // R6
    '{3'd4, 2'd2, 8'h80, 8'hFF, 8'h90, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 4'd7, 16'h0010, 1'b1, 5'd7}, // R1 R6 wrap
    '{3'd1, 2'd0, 8'hF0, 8'h55, 8'h20, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 4'd4, 16'h0010, 1'b0, 5'd4}, // R2
    '{3'd2, 2'd0, 8'h05, 8'h55, 8'h00, 8'hFF, 8'h00, 8'h00, 16'h0000, 1'b0, 4'd4, 16'h0004, 1'b0, 5'd4}, // R2
    '{3'd6, 2'd0, 8'hFE, 8'h00, 8'h01, 8'h00, 8'h34, 8'h12, 16'h0000, 1'b0, 4'd6, 16'h1234, 1'b0, 5'd6}, // R3
    '{3'd7, 2'd0, 8'hFF, 8'h00, 8'h00, 8'h10, 8'hF8, 8'h40, 16'h0000, 1'b0, 4'd5, 16'h4108, 1'b1, 5'd6}, // R4 R5
    '{3'd7, 2'd1, 8'h40, 8'h00, 8'h00, 8'h02, 8'h10, 8'h33, 16'h0000, 1'b0, 4'd6, 16'h3312, 1'b0, 5'd6}, // R4
    '{3'd0, 2'd3, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0280, 1'b1, 4'd2, 16'h0290, 1'b0, 5'd3}, // R7 R8
    '{3'd4, 2'd3, 8'h80, 8'h00, 8'h77, 8'h00, 8'h00, 8'h00, 16'h0350, 1'b1, 4'd2, 16'h02D0, 1'b1, 5'd4}, // R7 R8
    '{3'd0, 2'd3, 8'h7F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h04F0, 1'b0, 4'd2, 16'h056F, 1'b1, 5'd2}, // R7 R8
    '{3'd0, 2'd3, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0100, 1'b1, 4'd2, 16'h00FF, 1'b1, 5'd4}, // R7 R8
    '{3'd3, 2'd0, 8'hFF, 8'h12, 8'hFF, 8'hFF, 8'h00, 8'h00, 16'h0000, 1'b0, 4'd4, 16'h12FF, 1'b0, 5'd4}, // R2
    '{3'd0, 2'd0, 8'hAB, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 4'd3, 16'h00AB, 1'b0, 5'd3}, // R2
    '{3'd5, 2'd0, 8'h00, 8'h30, 8'h00, 8'hFF, 8'h00, 8'h00, 16'h0000, 1'b0, 4'd4, 16'h30FF, 1'b0, 5'd4}  // R1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode_sel = '0;
  logic [1:0]  class_sel = '0;
  logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
  logic [7:0]  ptr_lo_data = '0, ptr_hi_data = '0;
  logic [15:0] pc_next = '0;
  logic        br_taken = 1'b0;
  logic [3:0]  base_cycles = '0;
  logic [7:0]  ptr_lo_addr, ptr_hi_addr;
  logic [15:0] eff_addr;
  logic        page_cross;
  logic [4:0]  total_cycles;
  logic        out_valid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  addr_penalty_unit uut (
    .clk, .rst_n, .in_valid, .mode_sel, .class_sel, .op_lo, .op_hi, .idx_x, .idx_y,
    .ptr_lo_data, .ptr_hi_data, .pc_next, .br_taken, .base_cycles,
    .ptr_lo_addr, .ptr_hi_addr, .eff_addr, .page_cross, .total_cycles, .out_valid
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    in_valid    = vld;
    mode_sel    = v.mode;
    class_sel   = v.cls;
    op_lo       = v.lo;
    op_hi       = v.hi;
    idx_x       = v.x;
    idx_y       = v.y;
    ptr_lo_data = v.plo;
    ptr_hi_data = v.phi;
    pc_next     = v.pcn;
    br_taken    = v.tk;
    base_cycles = v.base;
  endtask

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 addr", 32'(eff_addr), 32'h0);
    chk("R10 cyc", 32'(total_cycles), 32'h0);
    chk("R10 valid/cross", {30'd0, out_valid, page_cross}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i], 1'b1);
      @(negedge clk);
      chk($sformatf("R9 valid vec%0d", i), 32'(out_valid), 32'h1);
      chk($sformatf("R1/R2/R3/R4/R7 addr vec%0d", i), 32'(eff_addr), 32'(TBL[i].e_addr));
      chk($sformatf("R1/R2/R4/R7 cross vec%0d", i), 32'(page_cross), 32'(TBL[i].e_cross));
      chk($sformatf("R5/R6/R8 cycles vec%0d", i), 32'(total_cycles), 32'(TBL[i].e_cyc));
    end

    // R3 pointer addresses wrap in page zero
    drive(TBL[6], 1'b1);
    #1;
    chk("R3 ptr lo", 32'(ptr_lo_addr), 32'hFF);
    chk("R3 ptr hi", 32'(ptr_hi_addr), 32'h00);
    // R4 pointer addresses from op_lo, high fetch wraps
    drive(TBL[7], 1'b1);
    #1;
    chk("R4 ptr lo", 32'(ptr_lo_addr), 32'hFF);
    chk("R4 ptr hi", 32'(ptr_hi_addr), 32'h00);
    @(negedge clk);
    chk("R4 addr", 32'(eff_addr), 32'h4108);

    // R9 idle cycle holds outputs although inputs change
    v = TBL[0];
    drive(v, 1'b0);
    @(negedge clk);
    chk("R9 idle valid", 32'(out_valid), 32'h0);
    chk("R9 idle addr hold", 32'(eff_addr), 32'h4108);
    chk("R9 idle cyc hold", 32'(total_cycles), 32'd6);

    // R10 width: base 15 taken branch crossing page gives 17
    v = TBL[10];
    v.base = 4'd15;
    drive(v, 1'b1);
    @(negedge clk);
    chk("R10 wide total", 32'(total_cycles), 32'd17);

    // R6 rmw via indirect indexed with cross keeps base
    v = TBL[7];
    v.cls = 2'd2;
    drive(v, 1'b1);
    @(negedge clk);
    chk("R6 rmw cross flag", 32'(page_cross), 32'h1);
    chk("R6 rmw cycles", 32'(total_cycles), 32'd5);

    // R8 untaken branch without cross
    v = TBL[9];
    v.tk = 1'b0;
    drive(v, 1'b1);
    @(negedge clk);
    chk("R8 untaken cycles", 32'(total_cycles), 32'd2);

    in_valid = 1'b0;
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule